// File: doc/BRIEF.md
# Machine-Cycle Strobe and Reset Sequencer

This block sets the bus timing of a small 8-bit controller core. One oscillator clock drives a phase counter that splits each machine cycle into twelve oscillator periods. From that phase the block produces the address-latch strobe, the active-low program-store read strobe and a machine-cycle tick. It also filters the asynchronous reset pin into a clean internal reset and decides, for each program-counter value, whether code comes from on-chip or off-chip storage.

An external data transfer flagged by the core removes strobes in a fixed pattern. A control bit can silence the address strobe except during such transfers. The external-access pin is captured once, at the moment reset ends. After that, only the program counter affects the fetch choice.

Top module: `bus_strobe_seq`

## Requirements
- R1: A machine cycle is 12 oscillator periods (phases 0 to 11). `mc_tick` is high for exactly the period of phase 11 in each cycle, and never while `core_rst` is high.
- R2: Outside reset, with no data transfer and `ale_off` low, `ale` is high for one period at phase 0 and for one period at phase 6 of every cycle, and low elsewhere.
- R3: In a cycle with `xdata_cycle` high, the phase-0 `ale` pulse is omitted and the phase-6 pulse is kept.
- R4: When `fetch_ext` is high and `xdata_cycle` is low, `psen_n` is low for one period at phase 3 and for one period at phase 9, and high elsewhere.
- R5: In a cycle with `xdata_cycle` high, `psen_n` stays high for all 12 phases.
- R6: While `fetch_ext` is low, `psen_n` stays high.
- R7: With `ale_off` high, `ale` pulses only at phase 6 of cycles with `xdata_cycle` high, and stays low in all other cycles.
- R8: The internal reset is raised only after `rst_pin` has been high for at least 24 oscillator periods, and no later than 26 periods after the pin rises. A pulse of 20 periods leaves `core_rst` low and does not disturb the strobes.
- R9: `core_rst` falls only at the end of phase 11, so the first period after reset is phase 0. While `core_rst` is high, `ale` is low and `psen_n` is high.
- R10: `ea_pin` is captured at the clock edge where `core_rst` falls. Later changes on the pin have no effect on `fetch_ext`.
- R11: `fetch_ext` is high when the captured access value is 0, or when `pc` is above 16'h0FFF. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Asynchronous reset pin, active high |
| ea_pin | input | 1 | External-access pin, captured when reset ends |
| pc | input | 16 | Program counter of the core |
| xdata_cycle | input | 1 | The current machine cycle performs an external data transfer |
| ale_off | input | 1 | Restricts the address strobe to data-transfer cycles |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| core_rst | output | 1 | Synchronised internal reset |
| fetch_ext | output | 1 | High when the current fetch goes to off-chip storage |
| mc_tick | output | 1 | High in the last oscillator period of each machine cycle |

## Verification
The hardest case to reach from the ports is the reset filter near its threshold. The bench must show that a pin pulse just short of the limit leaves the running phase sequence untouched, and that a long pulse is accepted between period 24 and period 26 and then released on a cycle boundary. To get there, the bench drives `rst_pin` at known clock edges and counts periods itself. After each release it regains phase alignment from the fall of `core_rst`, or from `mc_tick` after a rejected pulse. The captured-pin rule is covered by a reset with the pin low, followed by a change on the pin while the bench watches `fetch_ext`.

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq #(
  parameter int OSC_PER_MC = 12,
  parameter int HOLD_MC    = 2,
  parameter int PC_W       = 16,
  parameter logic [15:0] INT_TOP = 16'h0FFF
) (
  input  logic            clk,
  input  logic            rst_pin,
  input  logic            ea_pin,
  input  logic [PC_W-1:0] pc,
  input  logic            xdata_cycle,
  input  logic            ale_off,
  output logic            ale,
  output logic            psen_n,
  output logic            core_rst,
  output logic            fetch_ext,
  output logic            mc_tick
);
  localparam int PH_W   = $clog2(OSC_PER_MC);
  localparam int HOLD_N = HOLD_MC * OSC_PER_MC;
  localparam int CNT_W  = $clog2(HOLD_N + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSC_PER_MC - 1);
  localparam logic [PH_W-1:0] PH_ALE2 = PH_W'(OSC_PER_MC / 2);
  localparam logic [PH_W-1:0] PH_RD1  = PH_W'(OSC_PER_MC / 4);
  localparam logic [PH_W-1:0] PH_RD2  = PH_W'((3 * OSC_PER_MC) / 4);

  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] hold_cnt;
  logic             sync1, sync2, ea_q;

  wire accept  = sync2 && (hold_cnt == CNT_W'(HOLD_N - 1));
  wire release_now = core_rst && !sync2 && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    sync1 <= rst_pin;
    sync2 <= sync1;
  end

  always_ff @(posedge clk) begin
    if (!sync2)                        hold_cnt <= '0;
    else if (hold_cnt != CNT_W'(HOLD_N)) hold_cnt <= hold_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept)           phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                  phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept)           core_rst <= 1'b1;
    else if (release_now) core_rst <= 1'b0;
  end

  always_ff @(posedge clk)
    if (release_now) ea_q <= ea_pin;

  assign fetch_ext = !ea_q || (16'(pc) > INT_TOP);
  assign mc_tick   = !core_rst && (phase == PH_LAST);

  wire ale_first  = (phase == '0) && !xdata_cycle && !ale_off;
  wire ale_second = (phase == PH_ALE2) && (xdata_cycle || !ale_off);
  assign ale = !core_rst && (ale_first || ale_second);

  wire rd_slot = (phase == PH_RD1) || (phase == PH_RD2);
  assign psen_n = !(!core_rst && fetch_ext && !xdata_cycle && rd_slot);
endmodule

module bus_strobe_seq_chk #(
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst_pin,
  input logic            ale,
  input logic            psen_n,
  input logic            core_rst,
  input logic            fetch_ext,
  input logic            mc_tick,
  input logic            ea_q,
  input logic [PH_W-1:0] phase
);
  p_ale_single_r2: assert property (@(posedge clk) disable iff (core_rst)
    ale |=> !ale);
  p_psen_single_r4: assert property (@(posedge clk) disable iff (core_rst)
    !psen_n |=> psen_n);
  p_tick_single_r1: assert property (@(posedge clk) disable iff (core_rst)
    mc_tick |=> !mc_tick);
  p_int_no_psen_r6: assert property (@(posedge clk) disable iff (core_rst)
    !fetch_ext |-> psen_n);
  p_rst_quiet_r9: assert property (@(posedge clk) disable iff (rst_pin)
    core_rst |-> (!ale && psen_n && !mc_tick));
  p_release_boundary_r9: assert property (@(posedge clk) disable iff (rst_pin)
    $fell(core_rst) |-> (phase == '0));
  p_ea_hold_r10: assert property (@(posedge clk) disable iff (core_rst)
    !core_rst |=> $stable(ea_q));
endmodule

bind bus_strobe_seq bus_strobe_seq_chk #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_pin(rst_pin), .ale(ale), .psen_n(psen_n),
  .core_rst(core_rst), .fetch_ext(fetch_ext), .mc_tick(mc_tick),
  .ea_q(ea_q), .phase(phase)
);

// File: tb/sim_bus_strobe_seq.sv
module sim_bus_strobe_seq;
  logic clk = 1'b0;
  logic rst_pin, ea_pin, xdata_cycle, ale_off;
  logic [15:0] pc;
  logic ale, psen_n, core_rst, fetch_ext, mc_tick;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  bus_strobe_seq u0 (
    .clk(clk), .rst_pin(rst_pin), .ea_pin(ea_pin), .pc(pc),
    .xdata_cycle(xdata_cycle), .ale_off(ale_off), .ale(ale),
    .psen_n(psen_n), .core_rst(core_rst), .fetch_ext(fetch_ext),
    .mc_tick(mc_tick)
  );

  // {pc, xdata, ale_off, ale mask (bit = phase), read mask (bit = phase), fetch_ext}
  localparam logic [42:0] VEC [8] = '{
    {16'h0100, 1'b0, 1'b0, 12'h041, 12'h000, 1'b0},  // R2 R6 R11
    {16'h0FFF, 1'b0, 1'b0, 12'h041, 12'h000, 1'b0},  // R11 boundary
    {16'h1000, 1'b0, 1'b0, 12'h041, 12'h208, 1'b1},  // R4 R11
    {16'h1000, 1'b1, 1'b0, 12'h040, 12'h000, 1'b1},  // R3 R5
    {16'h1000, 1'b0, 1'b1, 12'h000, 12'h208, 1'b1},  // R7
    {16'h1000, 1'b1, 1'b1, 12'h040, 12'h000, 1'b1},  // R7 R3
    {16'h0200, 1'b1, 1'b0, 12'h040, 12'h000, 1'b0},  // R3 R6
    {16'hFFFF, 1'b0, 1'b0, 12'h041, 12'h208, 1'b1}   // R4 R11
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called at the falling edge inside phase 0; returns at the next phase 0.
  task automatic run_cycle(input logic [42:0] v, input string tag);
    pc = v[42:27]; xdata_cycle = v[26]; ale_off = v[25];
    for (int k = 0; k < 12; k++) begin
      #1;
      chk(ale == v[13+k], {tag, " ale"}, ale, v[13+k]);
      chk(psen_n == !v[1+k], {tag, " psen_n"}, psen_n, !v[1+k]);
      chk(mc_tick == (k == 11), "R1 mc_tick", mc_tick, k == 11);
      chk(fetch_ext == v[0], {tag, " fetch_ext"}, fetch_ext, v[0]);
      @(negedge clk);
    end
  endtask

  task automatic wait_release();
    int n = 0;
    rst_pin = 1'b0;
    while (core_rst && n < 40) begin
      @(negedge clk); n++;
    end
    chk(!core_rst, "R9 release", core_rst, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_pin = 1'b1; ea_pin = 1'b1; pc = '0; xdata_cycle = 1'b0; ale_off = 1'b0;
    repeat (30) @(negedge clk);
    #1;
    chk(core_rst, "R8 reset accepted", core_rst, 1);
    chk(!ale, "R9 ale quiet", ale, 0);
    chk(psen_n, "R9 psen_n quiet", psen_n, 1);
    chk(!mc_tick, "R1 no tick in reset", mc_tick, 0);
    @(negedge clk);
    wait_release();

    for (int i = 0; i < 8; i++) run_cycle(VEC[i], "R2-vector");

    // R8: a short pulse is rejected
    rst_pin = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!core_rst, "R8 short pulse", core_rst, 0);
    end
    rst_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk(!core_rst, "R8 short pulse end", core_rst, 0);
    while (!mc_tick) @(negedge clk);
    @(negedge clk);
    run_cycle(VEC[2], "R8 strobes intact");

    // R8 lower and upper acceptance bound, with the access pin low
    ea_pin = 1'b0;
    rst_pin = 1'b1;
    repeat (24) @(negedge clk);
    chk(!core_rst, "R8 not before 24", core_rst, 0);
    repeat (3) @(negedge clk);
    chk(core_rst, "R8 by 26", core_rst, 1);
    wait_release();
    run_cycle({16'h0000, 1'b0, 1'b0, 12'h041, 12'h208, 1'b1}, "R11 access low");
    ea_pin = 1'b1;
    run_cycle({16'h0000, 1'b0, 1'b0, 12'h041, 12'h208, 1'b1}, "R10 pin ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule